// File: doc/BRIEF.md
# DDR Mode Register Capture

This block sits on the device side of a DDR SDRAM command interface. On every rising clock edge it samples the command pins. It picks out the two register-load commands, the base mode load and the extended mode load, and stores the relevant address bits into the register that the bank address selects. The stored fields are decoded into ready-to-use outputs:

- burst length and burst ordering
- read latency in half-cycle units, so that a latency of 2.5 can be expressed
- a one-cycle DLL reset request
- DLL enable
- output drive strength
- data-strobe FET control (QFC) enable

The block also polices when a register load may happen. Every bank must be idle. Enough cycles must have passed since the last precharge. Once a load has been accepted, no further command may follow until the load-to-command delay has expired. A broken rule produces a one-cycle error pulse, and the rejected load leaves both registers as they were. Reserved field codes are accepted, but they set a sticky flag. The decoded outputs read as zero until the matching register has been written once.

Top module: `ddr_mode_capture`

## Requirements
- R1: After reset, modeValid, extValid, ruleErr, cfgInvalid and dllRstPulse are 0. burstLen, casLatHalf, burstInterleave, dllEnable, halfDrive and qfcEnable also read 0.
- R2: A register load is recognised only when all of the following hold at a rising edge: cke=1; csN, rasN, casN and weN all 0; ba[1]=0. If ba[0]=0, the base register is loaded; if ba[0]=1, the extended register is loaded. With cke=0 or ba[1]=1 the command changes no register.
- R3: Base bits [2:0] set the burst length: 001 gives burstLen=2, 010 gives 4, 011 gives 8, and any other code gives 0. Base bit [3] drives burstInterleave (1 means interleaved).
- R4: Base bits [6:4] set the read latency, output as casLatHalf in half cycles: 010 gives 4, 110 gives 5, 011 gives 6, and any other code gives 0.
- R5: Extended bit [0]=0 gives dllEnable=1. Extended bit [1] drives halfDrive. Extended bit [2] drives qfcEnable. While extValid=0, all three outputs read 0.
- R6: An accepted base load with address bit [8]=1 makes dllRstPulse high for exactly the cycle after the load edge.
- R7: A register load issued while any bankOpen bit is 1 is rejected as a rule error.
- R8: A register load is rejected unless at least TRP_CYC edges separate it from the last precharge command (rasN=0, casN=1, weN=0 with csN=0, cke=1). Out of reset this rule counts as already met.
- R9: Any command other than NOP (rasN=casN=weN=1) or deselect (csN=1) that arrives fewer than TMRD_CYC edges after an accepted load is a rule error. A rejected load does not restart this window.
- R10: A rule error sets ruleErr high for the single cycle after the offending edge, and neither register changes.
- R11: cfgInvalid is set by an accepted load that carries a reserved value, and only reset clears it. Reserved values are: a reserved burst-length or latency code; base bit [7]=1; a nonzero base bit [12:9]; or a nonzero extended bit [12:3]. The decoded fields still take the new value.
- R12: modeValid and extValid rise on the first accepted load of their register and stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; commands are ignored while low |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address; bit 0 selects the register, bit 1 must be 0 |
| addr | input | ADDR_W | Address bus, captured on a register load |
| bankOpen | input | NUM_BANKS | One bit per bank; 1 means the bank has an open row |
| modeValid | output | 1 | Base register has been loaded |
| extValid | output | 1 | Extended register has been loaded |
| burstLen | output | 4 | Burst length in beats; 0 if unloaded or reserved |
| burstInterleave | output | 1 | 1 for interleaved burst order |
| casLatHalf | output | 3 | Read latency in half cycles; 0 if unloaded or reserved |
| dllRstPulse | output | 1 | One-cycle DLL reset request |
| dllEnable | output | 1 | DLL enabled per extended register |
| halfDrive | output | 1 | Reduced output drive selected |
| qfcEnable | output | 1 | QFC control enabled |
| ruleErr | output | 1 | One-cycle pulse after an illegal command |
| cfgInvalid | output | 1 | Sticky flag for reserved field values |

## Verification
A wrong stored value in either register shows up on the decoded field outputs in the cycle right after the load edge. So does a lost valid bit, because the fields fall back to 0. Each command is therefore followed by a read of the outputs at the next falling edge. A timer that is off by one in the precharge or load-delay tracking only shows as a missing or spurious ruleErr pulse. Those windows are therefore hit exactly at their last illegal edge and their first legal edge. A rule check that wrongly lets a load through is caught because the field outputs change when they must stay fixed.

// File: rtl/ddr_mode_pkg.sv
package ddr_mode_pkg;
  // Strobes handed from the command control to the register datapath
  typedef struct packed {
    logic wrMode;    // accept a base register load
    logic wrExt;     // accept an extended register load
    logic ruleBad;   // a timing or idle rule was broken
    logic fieldBad;  // the accepted value carries reserved content
    logic dllRst;    // accepted base load requests a DLL reset
  } ctlStrobe_t;
endpackage

// File: rtl/ddr_mode_ctl.sv
module ddr_mode_ctl
  import ddr_mode_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int NUM_BANKS = 4,
  parameter int TRP_CYC   = 3,
  parameter int TMRD_CYC  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [1:0]           ba,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output ctlStrobe_t           strb
);
  localparam int TRP_W  = $clog2(TRP_CYC + 1);
  localparam int TMRD_W = $clog2(TMRD_CYC + 1);
  localparam logic [TRP_W-1:0]  TRP_LIM  = TRP_W'(TRP_CYC);
  localparam logic [TMRD_W-1:0] TMRD_LIM = TMRD_W'(TMRD_CYC);

  logic [TRP_W-1:0]  trpCnt;   // edges since last precharge, saturating
  logic [TMRD_W-1:0] mrdCnt;   // edges since last accepted load, saturating

  logic isCmd, isNop, anyCmd, isPre, isLoad;
  logic trpOk, mrdOk, allIdle, accept;
  logic blBad, clBad, modeBad, extBad;

  always_comb begin
    isCmd   = cke && !csN;
    isNop   = isCmd && rasN && casN && weN;
    anyCmd  = isCmd && !isNop;
    isPre   = isCmd && !rasN && casN && !weN;
    isLoad  = isCmd && !rasN && !casN && !weN && !ba[1];
    trpOk   = trpCnt >= TRP_LIM;
    mrdOk   = mrdCnt >= TMRD_LIM;
    allIdle = (bankOpen == '0);
    accept  = isLoad && mrdOk && trpOk && allIdle;

    blBad   = !(addr[2:0] inside {3'b001, 3'b010, 3'b011});
    clBad   = !(addr[6:4] inside {3'b010, 3'b011, 3'b110});
    modeBad = blBad || clBad || addr[7] || (addr[ADDR_W-1:9] != '0);
    extBad  = (addr[ADDR_W-1:3] != '0);

    strb.wrMode   = accept && !ba[0];
    strb.wrExt    = accept && ba[0];
    strb.ruleBad  = (anyCmd && !mrdOk) || (isLoad && (!trpOk || !allIdle));
    strb.fieldBad = ba[0] ? extBad : modeBad;
    strb.dllRst   = accept && !ba[0] && addr[8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trpCnt <= TRP_LIM;
      mrdCnt <= TMRD_LIM;
    end else begin
      if (isPre)
        trpCnt <= TRP_W'(1);
      else if (trpCnt < TRP_LIM)
        trpCnt <= trpCnt + TRP_W'(1);

      if (accept)
        mrdCnt <= TMRD_W'(1);
      else if (mrdCnt < TMRD_LIM)
        mrdCnt <= mrdCnt + TMRD_W'(1);
    end
  end
endmodule

// File: rtl/ddr_mode_regs.sv
module ddr_mode_regs
  import ddr_mode_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] addr,
  output logic              modeValid,
  output logic              extValid,
  output logic [3:0]        burstLen,
  output logic              burstInterleave,
  output logic [2:0]        casLatHalf,
  output logic              dllRstPulse,
  output logic              dllEnable,
  output logic              halfDrive,
  output logic              qfcEnable,
  output logic              ruleErr,
  output logic              cfgInvalid
);
  // Only the bits with a defined meaning are kept; reserved bits are flagged
  logic [6:0] modeReg;
  logic [2:0] extReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg     <= '0;
      extReg      <= '0;
      modeValid   <= 1'b0;
      extValid    <= 1'b0;
      cfgInvalid  <= 1'b0;
      ruleErr     <= 1'b0;
      dllRstPulse <= 1'b0;
    end else begin
      ruleErr     <= strb.ruleBad;
      dllRstPulse <= strb.dllRst;
      if (strb.wrMode) begin
        modeReg   <= addr[6:0];
        modeValid <= 1'b1;
      end
      if (strb.wrExt) begin
        extReg   <= addr[2:0];
        extValid <= 1'b1;
      end
      if ((strb.wrMode || strb.wrExt) && strb.fieldBad)
        cfgInvalid <= 1'b1;
    end
  end

  always_comb begin
    burstLen = 4'd0;
    if (modeValid) begin
      unique case (modeReg[2:0])
        3'b001:  burstLen = 4'd2;
        3'b010:  burstLen = 4'd4;
        3'b011:  burstLen = 4'd8;
        default: burstLen = 4'd0;
      endcase
    end
    casLatHalf = 3'd0;
    if (modeValid) begin
      unique case (modeReg[6:4])
        3'b010:  casLatHalf = 3'd4;
        3'b110:  casLatHalf = 3'd5;
        3'b011:  casLatHalf = 3'd6;
        default: casLatHalf = 3'd0;
      endcase
    end
    burstInterleave = modeValid && modeReg[3];
    dllEnable       = extValid && !extReg[0];
    halfDrive       = extValid && extReg[1];
    qfcEnable       = extValid && extReg[2];
  end
endmodule

// File: rtl/ddr_mode_capture.sv
module ddr_mode_capture
  import ddr_mode_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int NUM_BANKS = 4,
  parameter int TRP_CYC   = 3,
  parameter int TMRD_CYC  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [1:0]           ba,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output logic                 modeValid,
  output logic                 extValid,
  output logic [3:0]           burstLen,
  output logic                 burstInterleave,
  output logic [2:0]           casLatHalf,
  output logic                 dllRstPulse,
  output logic                 dllEnable,
  output logic                 halfDrive,
  output logic                 qfcEnable,
  output logic                 ruleErr,
  output logic                 cfgInvalid
);
  ctlStrobe_t strb;

  ddr_mode_ctl #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS),
    .TRP_CYC(TRP_CYC), .TMRD_CYC(TMRD_CYC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .ba(ba), .addr(addr),
    .bankOpen(bankOpen), .strb(strb)
  );

  ddr_mode_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr),
    .modeValid(modeValid), .extValid(extValid), .burstLen(burstLen),
    .burstInterleave(burstInterleave), .casLatHalf(casLatHalf),
    .dllRstPulse(dllRstPulse), .dllEnable(dllEnable),
    .halfDrive(halfDrive), .qfcEnable(qfcEnable),
    .ruleErr(ruleErr), .cfgInvalid(cfgInvalid)
  );
endmodule

// File: rtl/ddr_mode_capture_chk.sv
module ddr_mode_capture_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cke,
  input logic                 csN,
  input logic                 rasN,
  input logic                 casN,
  input logic                 weN,
  input logic [1:0]           ba,
  input logic [NUM_BANKS-1:0] bankOpen,
  input logic                 modeValid,
  input logic                 extValid,
  input logic [3:0]           burstLen,
  input logic [2:0]           casLatHalf,
  input logic                 dllRstPulse,
  input logic                 dllEnable,
  input logic                 ruleErr,
  input logic                 cfgInvalid
);
  // R7
  busy_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cke && !csN && !rasN && !casN && !weN && !ba[1] && (bankOpen != '0)) |=> ruleErr);

  // R10
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ruleErr |-> ($stable(burstLen) && $stable(casLatHalf) && $stable(dllEnable)
                 && $stable(modeValid) && $stable(extValid)));

  // R11
  sticky_bad_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgInvalid |=> cfgInvalid);

  // R12
  sticky_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeValid |=> modeValid) and (extValid |=> extValid));

  // R3
  burst_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstLen inside {4'd0, 4'd2, 4'd4, 4'd8});

  // R4
  lat_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    casLatHalf inside {3'd0, 3'd4, 3'd5, 3'd6});

  // R6
  dll_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dllRstPulse |-> (modeValid && !ruleErr));

  // R5
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !extValid |-> !dllEnable);
endmodule

bind ddr_mode_capture ddr_mode_capture_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/test_ddr_mode_capture.sv
module test_ddr_mode_capture;
  logic        clk = 1'b0;
  logic        rstN, cke, csN, rasN, casN, weN;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [3:0]  bankOpen;
  logic        modeValid, extValid, burstInterleave, dllRstPulse;
  logic        dllEnable, halfDrive, qfcEnable, ruleErr, cfgInvalid;
  logic [3:0]  burstLen;
  logic [2:0]  casLatHalf;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ddr_mode_capture #(.ADDR_W(13), .NUM_BANKS(4), .TRP_CYC(3), .TMRD_CYC(2)) i_ddr_mode_capture (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .bankOpen(bankOpen),
    .modeValid(modeValid), .extValid(extValid), .burstLen(burstLen),
    .burstInterleave(burstInterleave), .casLatHalf(casLatHalf),
    .dllRstPulse(dllRstPulse), .dllEnable(dllEnable), .halfDrive(halfDrive),
    .qfcEnable(qfcEnable), .ruleErr(ruleErr), .cfgInvalid(cfgInvalid)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive pins for exactly one rising edge; return at the next falling edge
  task automatic drv(input logic c, input logic r, input logic ca, input logic w,
                     input logic [1:0] b, input logic [12:0] a);
    csN = c; rasN = r; casN = ca; weN = w; ba = b; addr = a;
    @(negedge clk);
  endtask

  task automatic nop();
    drv(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 13'h0);
  endtask

  task automatic load(input logic [1:0] b, input logic [12:0] a);
    drv(1'b0, 1'b0, 1'b0, 1'b0, b, a);
  endtask

  task automatic t_reset();
    check("R1 modeValid", modeValid, 0);
    check("R1 extValid", extValid, 0);
    check("R1 burstLen", burstLen, 0);
    check("R1 casLatHalf", casLatHalf, 0);
    check("R1 dllEnable", dllEnable, 0);
    check("R1 ruleErr", ruleErr, 0);
    check("R1 cfgInvalid", cfgInvalid, 0);
  endtask

  task automatic t_ext_load();
    load(2'b01, 13'b010);
    check("R2 extValid", extValid, 1);
    check("R5 dllEnable", dllEnable, 1);
    check("R5 halfDrive", halfDrive, 1);
    check("R5 qfcEnable", qfcEnable, 0);
    check("R12 modeValid still low", modeValid, 0);
    nop();
  endtask

  task automatic t_mode_patterns();
    load(2'b00, 13'h162);          // BL4 seq, latency 2.5, DLL reset
    check("R3 burstLen 4", burstLen, 4);
    check("R3 sequential", burstInterleave, 0);
    check("R4 latency 2.5", casLatHalf, 5);
    check("R6 pulse high", dllRstPulse, 1);
    check("R12 modeValid", modeValid, 1);
    nop();
    check("R6 pulse one cycle", dllRstPulse, 0);
    check("R9 NOP inside window", ruleErr, 0);
    load(2'b00, 13'h03B);          // BL8 interleaved, latency 3
    check("R3 burstLen 8", burstLen, 8);
    check("R3 interleaved", burstInterleave, 1);
    check("R4 latency 3", casLatHalf, 6);
    check("R6 no pulse", dllRstPulse, 0);
    drv(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 13'h0);  // deselect inside window
    check("R9 deselect inside window", ruleErr, 0);
    load(2'b00, 13'h021);          // BL2, latency 2
    check("R3 burstLen 2", burstLen, 2);
    check("R4 latency 2", casLatHalf, 4);
    nop();
  endtask

  task automatic t_mrd();
    load(2'b00, 13'h03B);
    load(2'b00, 13'h021);          // one edge later
    check("R9 back-to-back error", ruleErr, 1);
    check("R10 burstLen kept", burstLen, 8);
    nop();
    check("R10 error single cycle", ruleErr, 0);
    load(2'b00, 13'h021);
    check("R9 load after window", ruleErr, 0);
    check("R9 load accepted", burstLen, 2);
    drv(1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 13'h0);  // activate too soon
    check("R9 other command error", ruleErr, 1);
    nop();
  endtask

  task automatic t_idle();
    bankOpen = 4'b0100;
    load(2'b00, 13'h03B);
    check("R7 open bank error", ruleErr, 1);
    check("R7 burstLen kept", burstLen, 2);
    bankOpen = 4'b0000;
    nop();
  endtask

  task automatic t_trp();
    nop();
    drv(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 13'h400);  // precharge all
    nop();
    load(2'b00, 13'h03B);          // two edges after precharge
    check("R8 early load error", ruleErr, 1);
    check("R8 burstLen kept", burstLen, 2);
    load(2'b00, 13'h03B);          // three edges after precharge
    check("R8 boundary accepted", ruleErr, 0);
    check("R8 burstLen updated", burstLen, 8);
    nop();
  endtask

  task automatic t_reserved();
    load(2'b00, 13'h017);          // BL code 7, latency code 1
    check("R11 flag set", cfgInvalid, 1);
    check("R3 reserved length", burstLen, 0);
    check("R4 reserved latency", casLatHalf, 0);
    check("R11 no rule error", ruleErr, 0);
    nop();
    load(2'b00, 13'h03B);
    check("R11 flag sticky", cfgInvalid, 1);
    check("R11 fields still load", burstLen, 8);
    nop();
  endtask

  task automatic t_ignored();
    cke = 1'b0;
    load(2'b00, 13'h021);
    check("R2 cke low ignored", burstLen, 8);
    check("R2 cke low no error", ruleErr, 0);
    cke = 1'b1;
    nop();
    nop();
    load(2'b10, 13'h021);
    check("R2 ba1 high ignored", burstLen, 8);
    check("R2 ba1 high ext kept", halfDrive, 1);
    nop();
    load(2'b01, 13'b101);
    check("R5 DLL disabled", dllEnable, 0);
    check("R5 qfc enabled", qfcEnable, 1);
    check("R5 full drive", halfDrive, 0);
    check("R12 extValid stays", extValid, 1);
    nop();
  endtask

  initial begin
    rstN = 1'b0; cke = 1'b1; csN = 1'b1; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
    ba = 2'b00; addr = '0; bankOpen = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ext_load();
    t_mode_patterns();
    t_mrd();
    t_idle();
    t_trp();
    t_reserved();
    t_ignored();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule